// File: doc/BRIEF.md
# DRAM bank row sequencer with refresh

This block sequences one bank of a one-transistor-one-capacitor memory array. It accepts read and write requests over a valid/ready handshake. Each request carries a row, a column and, for writes, a data word. The block drives the array's phase controls: bitline precharge, wordline enable with a row index, sense-amplifier enable, and column select with write strobe and address. Every phase is held for a parameterised number of clock cycles. The block keeps one row open (open-page policy). A request to that row goes straight to the column phase. A request to any other row first closes the open row, precharges the bitlines and then opens the new row.

A refresh engine raises a request at a fixed interval. The interval is the retention window in cycles divided by the row count. While the hot-mode input is high, the interval is halved. Each refresh opens the next row in a wrapping sequence, lets the sense amplifier restore its charge, and closes it again. A refresh drives no column select and returns no data. While a refresh is due or in progress, the handshake ready is low. A refresh that falls due during a host access waits until that column access completes, then closes the open row and runs.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, and before every wordline rise, the precharge output (bl_pre_o) is high for at least T_PRE consecutive cycles with the wordline low. Precharge and wordline are never high together. Out of reset, ready first rises T_PRE cycles after reset is released.
- R2: The sense enable rises exactly T_DEV cycles after the wordline rises.
- R3: The sense enable stays high with the wordline high for at least T_RES cycles before any column select or wordline fall. For a refresh, the wordline falls exactly T_RES cycles after the sense enable rises.
- R4: A close drives the wordline and sense enable low for one cycle with precharge low. Precharge rises in the next cycle. No row opens until R1's precharge interval has run.
- R5: Column select is high only while the row is open, and it lasts exactly T_COL cycles. Counted in cycles from the accepting edge to the read response, latencies are: T_COL+1 for a hit on the open row; T_DEV+T_RES+T_COL+1 from the closed state; 1+T_PRE+T_DEV+T_RES+T_COL+1 for a different row while a row is open.
- R6: Refresh rows go 0, 1, 2, … and wrap from 2^ROW_W−1 back to 0.
- R7: With the host idle, refreshes start exactly WINDOW_CYC/2^ROW_W cycles apart. With hot_i high, they start half that many cycles apart.
- R8: A refresh drives no column select and produces no response.
- R9: Ready is low while a refresh is due or in progress. A request raised in the first wordline cycle of a refresh sees ready T_DEV+T_RES+1+T_PRE cycles later.
- R10: A read returns rsp_valid_o as a one-cycle pulse in the cycle after its last column-select cycle. rsp_data_o carries the array data sampled in that last cycle. A write drives col_we_o and col_wdata_o during column select and returns no response.
- R11: A refresh that falls due during a host access lets that access complete, then closes the open row. The next request to that row is served with the closed-state latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hot_i | input | 1 | Halves the refresh interval |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted on a clock edge when both are high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_data_o | output | DATA_W | Read data |
| bl_pre_o | output | 1 | Bitline precharge to mid-supply |
| wl_en_o | output | 1 | Wordline raised |
| wl_row_o | output | ROW_W | Row whose wordline is driven |
| sa_en_o | output | 1 | Sense amplifier enable |
| col_sel_o | output | 1 | Column select |
| col_we_o | output | 1 | Column write strobe |
| col_addr_o | output | COL_W | Column address |
| col_wdata_o | output | DATA_W | Column write data |
| col_rdata_i | input | DATA_W | Array data of the selected column |

## Verification
The assertions assume two things about the inputs. First, every phase count is at least one. Second, the refresh interval, halved or not, is longer than one refresh plus the longest host access, so a new refresh never falls due while the previous one is still pending. The host is assumed to hold a request stable from valid until it is accepted, and the array data is assumed to follow the row and column outputs combinationally. The bench uses a small configuration with a 128-cycle interval (64 in hot mode) and phases of a few cycles. It holds each request until it sees ready, and it times latency checks to start just after a refresh ends, so that no refresh falls inside the measured span.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    PH_PRE, PH_IDLE, PH_ACT, PH_SENSE, PH_OPEN, PH_COL, PH_CLOSE
  } phase_e;
endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int unsigned W    = 4,
  parameter int unsigned INIT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= W'(INIT);
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned ROW_W      = 3,
  parameter int unsigned WINDOW_CYC = 2048
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hot_i,
  input  logic             take_i,
  output logic             due_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned ROWS = 1 << ROW_W;
  localparam int unsigned INTV = WINDOW_CYC / ROWS;
  localparam int unsigned HOT  = INTV / 2;
  localparam int unsigned CW   = $clog2(INTV + 1);
  localparam logic [CW-1:0]    LIM_N   = CW'(INTV - 1);
  localparam logic [CW-1:0]    LIM_H   = CW'(HOT - 1);
  localparam logic [ROW_W-1:0] ROW_TOP = ROW_W'(ROWS - 1);

  logic [CW-1:0]    cnt_q;
  logic             due_q, tick;
  logic [ROW_W-1:0] row_q;

  assign tick = cnt_q >= (hot_i ? LIM_H : LIM_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      due_q <= 1'b0;
      row_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      due_q <= tick | (due_q & ~take_i);
      if (take_i) row_q <= (row_q == ROW_TOP) ? '0 : row_q + 1'b1;
    end
  end

  assign due_o = due_q;
  assign row_o = row_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (!due_q || take_i));
  p_take_due_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> due_q);
  p_row_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && row_q == ROW_TOP) |=> (row_q == '0));
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned ROW_W      = 3,
  parameter int unsigned COL_W      = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned T_PRE      = 3,
  parameter int unsigned T_DEV      = 2,
  parameter int unsigned T_RES      = 4,
  parameter int unsigned T_COL      = 2,
  parameter int unsigned WINDOW_CYC = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hot_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              bl_pre_o,
  output logic              wl_en_o,
  output logic [ROW_W-1:0]  wl_row_o,
  output logic              sa_en_o,
  output logic              col_sel_o,
  output logic              col_we_o,
  output logic [COL_W-1:0]  col_addr_o,
  output logic [DATA_W-1:0] col_wdata_o,
  input  logic [DATA_W-1:0] col_rdata_i
);
  localparam int unsigned T_A  = (T_PRE > T_DEV) ? T_PRE : T_DEV;
  localparam int unsigned T_B  = (T_RES > T_COL) ? T_RES : T_COL;
  localparam int unsigned TMAX = (T_A > T_B) ? T_A : T_B;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  phase_e            state_q, state_n;
  logic              t_load, t_done;
  logic [TW-1:0]     t_val;
  logic              ref_due, take, acc;
  logic [ROW_W-1:0]  ref_row;
  logic              go_open_q, go_open_n, is_ref_q, is_ref_n;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;

  dram_refresh_sched #(.ROW_W(ROW_W), .WINDOW_CYC(WINDOW_CYC)) u_sched (
    .clk_i, .rst_ni, .hot_i,
    .take_i(take), .due_o(ref_due), .row_o(ref_row)
  );

  dram_phase_timer #(.W(TW), .INIT(T_PRE - 1)) u_timer (
    .clk_i, .rst_ni, .load_i(t_load), .val_i(t_val), .done_o(t_done)
  );

  always_comb begin
    state_n   = state_q;
    take      = 1'b0;
    acc       = 1'b0;
    go_open_n = go_open_q;
    is_ref_n  = is_ref_q;
    unique case (state_q)
      PH_PRE:   if (t_done) state_n = go_open_q ? PH_ACT : PH_IDLE;
      PH_IDLE: begin
        if (ref_due) begin
          take = 1'b1; is_ref_n = 1'b1; state_n = PH_ACT;
        end else if (req_valid_i) begin
          acc = 1'b1; is_ref_n = 1'b0; state_n = PH_ACT;
        end
      end
      PH_ACT:   if (t_done) state_n = PH_SENSE;
      PH_SENSE: if (t_done) begin
        state_n   = is_ref_q ? PH_CLOSE : PH_COL;
        go_open_n = 1'b0;
      end
      PH_COL:   if (t_done) state_n = PH_OPEN;
      PH_OPEN: begin
        if (ref_due) begin
          // drain the page first, refresh row opens after precharge
          take = 1'b1; is_ref_n = 1'b1; go_open_n = 1'b1; state_n = PH_CLOSE;
        end else if (req_valid_i) begin
          acc = 1'b1; is_ref_n = 1'b0;
          if (req_row_i == row_q) state_n = PH_COL;
          else begin
            go_open_n = 1'b1; state_n = PH_CLOSE;
          end
        end
      end
      PH_CLOSE: state_n = PH_PRE;
      default:  state_n = PH_PRE;
    endcase
  end

  assign t_load = (state_n != state_q);
  always_comb begin
    unique case (state_n)
      PH_PRE:   t_val = TW'(T_PRE - 1);
      PH_ACT:   t_val = TW'(T_DEV - 1);
      PH_SENSE: t_val = TW'(T_RES - 1);
      PH_COL:   t_val = TW'(T_COL - 1);
      default:  t_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PH_PRE;
      go_open_q <= 1'b0;
      is_ref_q  <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      rsp_q     <= 1'b0;
    end else begin
      state_q   <= state_n;
      go_open_q <= go_open_n;
      is_ref_q  <= is_ref_n;
      if (take) row_q <= ref_row;
      if (acc) begin
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      rsp_q <= (state_q == PH_COL) && t_done && !we_q;
      if ((state_q == PH_COL) && t_done && !we_q) rdata_q <= col_rdata_i;
    end
  end

  assign req_ready_o = ((state_q == PH_IDLE) || (state_q == PH_OPEN)) && !ref_due;
  assign bl_pre_o    = (state_q == PH_PRE) || (state_q == PH_IDLE);
  assign wl_en_o     = (state_q == PH_ACT) || (state_q == PH_SENSE) ||
                       (state_q == PH_OPEN) || (state_q == PH_COL);
  assign sa_en_o     = (state_q == PH_SENSE) || (state_q == PH_OPEN) ||
                       (state_q == PH_COL);
  assign wl_row_o    = row_q;
  assign col_sel_o   = (state_q == PH_COL);
  assign col_we_o    = col_sel_o && we_q;
  assign col_addr_o  = col_q;
  assign col_wdata_o = wdata_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_data_o  = rdata_q;

  p_pre_wl_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_pre_o |-> !wl_en_o);
  p_sa_under_wl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sa_en_o |-> wl_en_o);
  p_col_in_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_sel_o |-> (sa_en_o && wl_en_o));
  p_row_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wl_en_o && $past(wl_en_o)) |-> $stable(wl_row_o));
  p_close_pre_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wl_en_o) |=> bl_pre_o);
  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ref_q && wl_en_o) |-> !req_ready_o);
  p_ref_no_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref_q |-> (!col_sel_o && !rsp_valid_o));
  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/dram_bank_seq_test.sv
`timescale 1ns/1ps
module dram_bank_seq_test;
  localparam int ROW_W = 2, COL_W = 2, DW = 8;
  localparam int TP = 2, TD = 2, TR = 3, TC = 2, WIN = 512;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W, INTV = WIN / ROWS;

  logic clk = 1'b0, rst_n = 1'b0, hot = 1'b0;
  logic req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, bl_pre, wl_en, sa_en, col_sel, col_we;
  logic [DW-1:0] rsp_data, col_wdata, col_rdata;
  logic [ROW_W-1:0] wl_row;
  logic [COL_W-1:0] col_addr;

  always #4 clk = ~clk;

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_PRE(TP), .T_DEV(TD),
                  .T_RES(TR), .T_COL(TC), .WINDOW_CYC(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hot_i(hot),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_row_i(req_row), .req_col_i(req_col), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .bl_pre_o(bl_pre), .wl_en_o(wl_en), .wl_row_o(wl_row), .sa_en_o(sa_en),
    .col_sel_o(col_sel), .col_we_o(col_we), .col_addr_o(col_addr),
    .col_wdata_o(col_wdata), .col_rdata_i(col_rdata)
  );

  // array model
  logic [DW-1:0] arr [ROWS*COLS];
  assign col_rdata = arr[{wl_row, col_addr}];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS*COLS; i++) arr[i] <= '0;
    end else if (col_sel && col_we) arr[{wl_row, col_addr}] <= col_wdata;
  end

  int vecs = 0, errs = 0;
  bit fin = 1'b0;
  logic [DW-1:0] shadow [ROWS*COLS];
  logic [DW-1:0] exp_data;
  bit rd_out = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // phase monitor
  int pre_run = 0, wl_run = 0, sa_run = 0, col_run = 0;
  bit prev_wl = 0, prev_sa = 0, prev_col = 0, ep_col = 0;
  int ep_row = 0, ep_start = 0, cyc = 0, ref_exp = 0, ref_cnt = 0;
  int ref_t_prev = 0, ref_t_last = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pre_run = 0; wl_run = 0; sa_run = 0; col_run = 0;
      prev_wl = 0; prev_sa = 0; prev_col = 0;
    end else begin
      cyc++;
      if (bl_pre && wl_en) chk(1'b0, "R1 pre with wordline", 1, 0);
      if (wl_en && !prev_wl) begin
        chk(pre_run >= TP, "R1 precharge before open", pre_run, TP);
        ep_col = 0; ep_row = int'(wl_row); ep_start = cyc;
      end
      if (sa_en && !prev_sa) chk(wl_run == TD, "R2 signal development", wl_run, TD);
      if (col_sel && !prev_col) begin
        chk(sa_run >= TR, "R3 restore before column", sa_run, TR);
        ep_col = 1;
      end
      if (!col_sel && prev_col) chk(col_run == TC, "R5 column length", col_run, TC);
      if (!wl_en && prev_wl) begin
        chk(!bl_pre && !sa_en, "R4 close cycle all low", int'(bl_pre), 0);
        if (!ep_col) begin
          chk(sa_run == TR, "R3 refresh restore length", sa_run, TR);
          chk(ep_row == ref_exp, "R6 refresh row order", ep_row, ref_exp);
          ref_exp = (ref_exp + 1) % ROWS;
          ref_t_prev = ref_t_last; ref_t_last = ep_start;
          ref_cnt++;
        end else begin
          chk(sa_run >= TR, "R3 restore before close", sa_run, TR);
        end
      end
      if (rsp_valid) begin
        if (!rd_out) chk(1'b0, "R8 R10 unexpected response", 1, 0);
        rd_out = 0;
      end
      pre_run = bl_pre  ? pre_run + 1 : 0;
      wl_run  = wl_en   ? wl_run + 1  : 0;
      sa_run  = sa_en   ? sa_run + 1  : 0;
      col_run = col_sel ? col_run + 1 : 0;
      prev_wl = wl_en; prev_sa = sa_en; prev_col = col_sel;
    end
  end

  task automatic host_op(input bit we, input int row, input int col, input int d,
                         output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_row = ROW_W'(row); req_col = COL_W'(col);
    req_wdata = DW'(d);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    if (we) shadow[row*COLS+col] = DW'(d);
    else begin
      rd_out = 1'b1;
      exp_data = shadow[row*COLS+col];
      lat = 1;
      while (!rsp_valid) begin @(negedge clk); lat++; end
      chk(rsp_data == exp_data, "R10 read data", int'(rsp_data), int'(exp_data));
    end
  endtask

  task automatic wait_ref_done();
    int r;
    r = ref_cnt;
    while (ref_cnt == r) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    int n, lat;
    for (int i = 0; i < ROWS*COLS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk(bl_pre && !wl_en && !sa_en && !col_sel && !req_ready && !rsp_valid,
        "R1 reset state", int'(bl_pre), 1);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready);
    chk(n == TP, "R1 first ready after reset", n, TP);

    // timed accesses in the gap after a refresh
    wait_ref_done();
    host_op(0, 1, 2, 0, lat);
    chk(lat == TD+TR+TC+1, "R5 miss from closed", lat, TD+TR+TC+1);
    host_op(1, 1, 2, 8'h5a, lat);
    host_op(0, 1, 2, 0, lat);
    chk(lat == TC+1, "R5 hit on open row", lat, TC+1);
    host_op(0, 2, 0, 0, lat);
    chk(lat == 1+TP+TD+TR+TC+1, "R5 miss from open", lat, 1+TP+TD+TR+TC+1);

    // refresh arrives with row 2 open, request raised at refresh start
    do @(negedge clk); while (wl_en);
    do @(negedge clk); while (!wl_en);
    req_valid = 1'b1; req_we = 1'b0; req_row = 2'd2; req_col = 2'd0;
    n = 0;
    while (!req_ready) begin @(negedge clk); n++; end
    chk(n == TD+TR+1+TP, "R9 stall during refresh", n, TD+TR+1+TP);
    @(negedge clk);
    req_valid = 1'b0; rd_out = 1'b1; exp_data = shadow[2*COLS];
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    chk(lat == TD+TR+TC+1, "R11 row closed by refresh", lat, TD+TR+TC+1);
    chk(rsp_data == exp_data, "R10 read after stall", int'(rsp_data), int'(exp_data));

    // interval checks with the host idle
    repeat (4*INTV) @(negedge clk);
    chk(ref_t_last - ref_t_prev == INTV, "R7 normal interval", ref_t_last - ref_t_prev, INTV);
    hot = 1'b1;
    repeat (4*(INTV/2)) @(negedge clk);
    chk(ref_t_last - ref_t_prev == INTV/2, "R7 hot interval", ref_t_last - ref_t_prev, INTV/2);
    hot = 1'b0;

    // full sweep, refreshes interleave freely (R11)
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        host_op(1, r, c, 8'h30 + r*16 + c, lat);
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        host_op(0, r, c, 0, lat);
    hot = 1'b1;
    for (int r = ROWS-1; r >= 0; r--) host_op(0, r, r, 0, lat);
    hot = 1'b0;
    repeat (20) @(negedge clk);
    chk(ref_cnt > ROWS, "R6 refresh wrapped", ref_cnt, ROWS+1);
    chk(!rd_out, "R8 all responses seen", int'(rd_out), 0);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule